// File: doc/BRIEF.md
# Multi-Line Serial Register Front End

This block is the host-facing register window of an eight-line serial multiplexer. The host sees two 16-bit words. The first is a control/status word. It holds a five-bit indirect pointer, the two interrupt enables, the transmit and receive interrupt flags, and a self-clearing master reset. The second is a shared indirect data word. Its meaning depends on the pointer: the low three pointer bits pick a line, and the upper two pick one of four per-line registers. Those registers are the transmit character port, the line control and transmit modem status pair, the transmit address, and the transmit count.

The serial engines, silos and DMA machinery sit outside. They see every line's stored control state on flat output buses. They receive a one-cycle push strobe when the host writes a character. They supply per-line silo counts and receive modem status for readback. Transmit-done events from the engines are queued in arrival order. The host takes each event out of the queue by reading the control/status word.

Top module: `mux_regfront`

## Requirements
- R1: After synchronous reset, the control/status word reads 0, every per-line register is 0, and both interrupt outputs are low.
- R2: Control/status fields are laid out as follows:
  - Writable: the pointer in bits 4:0, receive enable in bit 6 and transmit enable in bit 14. All of these read back.
  - Read-only, writes ignored: bit 15 (transmit flag), bit 13 (memory error), bits 10:8 (event line) and bit 7 (receive flag).
- R3: With pointer group 01, the indirect low byte is the selected line's 6-bit line control. The high byte is its transmit modem status: bits 0-5 and bit 7 are kept, and bit 6 reads 0. No other line changes.
- R4: Groups 10 and 11 hold a 16-bit transmit address and a 16-bit transmit count per line. Each is independent of the other and of other lines.
- R5: Byte enables on the indirect word update only the enabled byte of the selected register.
- R6: Writing the low byte with group 00 gives a one-cycle push strobe on the selected line only, carrying that byte. A high-byte-only write gives no strobe. A group 00 read returns the line's silo count in the low byte and its receive modem status in the high byte, masked to bits 7:2.
- R7: Transmit events are kept in arrival order. While any is pending, bit 15 is set, bits 10:8 show the oldest event's line and bit 13 shows its memory-error flag.
- R8: A control/status read while bit 15 is set removes the oldest event. An event arriving in the same cycle as that read is still queued.
- R9: When the queue holds EVQ_DEPTH events, further arrivals are dropped.
- R10: A receive event sets bit 7. A control/status read clears it, unless a new receive event arrives in the same cycle, in which case it stays set.
- R11: The transmit interrupt output is bit 15 AND bit 14. The receive interrupt output is bit 7 AND bit 6.
- R12: Writing 1 to bit 5 sets that bit for exactly one cycle, with mreset_o high. At the end of that cycle, the following are all cleared and bit 5 returns to 0:
  - every per-line register;
  - the pointer;
  - both enables;
  - the receive flag;
  - the event queue.
  Host writes during that cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | 0 = control/status word, 1 = indirect word |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe (a control/status read pops/clears) |
| host_be | input | 2 | Byte enables, bit 0 = low byte |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for the addressed word |
| tx_evt_i | input | 1 | Transmit-done event pulse |
| tx_evt_line_i | input | 3 | Line of the event |
| tx_evt_nxm_i | input | 1 | Event carries a memory error |
| rx_evt_i | input | 1 | Receive event pulse |
| tx_irq_o | output | 1 | Transmit interrupt request |
| rx_irq_o | output | 1 | Receive interrupt request |
| mreset_o | output | 1 | Master reset in progress |
| txb_push_o | output | 8 | Per-line character push strobe |
| txb_data_o | output | 8 | Character being pushed |
| tsc_i | input | 64 | Per-line transmit silo count, 8 bits each |
| rms_i | input | 64 | Per-line receive modem status, 8 bits each |
| lctl_o | output | 64 | Per-line line control |
| tms_o | output | 64 | Per-line transmit modem status |
| taddr_o | output | 128 | Per-line transmit address |
| tcnt_o | output | 128 | Per-line transmit count |

## Verification
Two functions can land in the same cycle:
- a host read of the control/status word, which pops the oldest transmit event, and a new transmit event from an engine;
- that same read, which clears the receive flag, and a new receive event.

The bench raises the event inputs during the very read cycle. It judges the outcome on the next reads:
- the popped event was the one shown;
- the new transmit event is present after it;
- the receive flag reads clear during the collision and set on the following read.

A master reset issued with an event pending shows the other overlap: the reset cycle must drop both the pending event and the read's pop.

// File: rtl/mxr_pkg.sv
// Package: shared field positions, masks, group codes and the event record
// for the multi-line register front end. Assumes at most eight lines.
package mxr_pkg;
    localparam int LINE_BITS = 3;

    // Register groups selected by pointer bits 4:3.
    typedef enum logic [1:0] {
        GRP_TXBUF = 2'b00,
        GRP_LCTL  = 2'b01,
        GRP_TADDR = 2'b10,
        GRP_TCNT  = 2'b11
    } grp_e;

    // Bit positions in the control/status word.
    localparam int CSR_TI  = 15;
    localparam int CSR_TIE = 14;
    localparam int CSR_NXM = 13;
    localparam int CSR_RI  = 7;
    localparam int CSR_RIE = 6;
    localparam int CSR_CLR = 5;

    // Implemented bits of the per-line byte registers.
    localparam logic [7:0] LCTL_MASK = 8'h3F;
    localparam logic [7:0] TMS_MASK  = 8'hBF;
    localparam logic [7:0] RMS_MASK  = 8'hFC;

    typedef struct packed {
        logic [LINE_BITS-1:0] line;
        logic                 nxm;
    } tx_evt_t;
endpackage

// File: rtl/mxr_evq.sv
// Module: in-order queue of transmit-done events.
// Assumes DEPTH is a power of two (pointers wrap naturally).
// A pop and a push in one cycle both take effect, even when the queue is full.
// flush empties the queue.
module mxr_evq
    import mxr_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    flush,
    input  logic    push,
    input  tx_evt_t push_data,
    input  logic    pop,
    output logic    head_valid,
    output tx_evt_t head
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    tx_evt_t          mem [DEPTH];
    logic [PW-1:0]    rd_ptr, wr_ptr;
    logic [CW-1:0]    count;
    logic             empty, full, do_pop, do_push;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // Event storage; contents need no reset because empty masks the head.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    assign head_valid = !empty;
    assign head       = mem[rd_ptr];

    // R9: an arrival into a full queue without a pop is dropped.
    assert_full_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (full && $stable(wr_ptr)));

    // R8: simultaneous pop and push keep the occupancy unchanged.
    assert_push_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !empty && !flush) |=> (count == $past(count)));
endmodule

// File: rtl/mxr_line_bank.sv
// Module: per-line indirect registers, character push strobes and the
// readback multiplexer for the line/group named by the pointer.
// Assumes NUM_LINES is a power of two no larger than eight.
module mxr_line_bank
    import mxr_pkg::*;
#(
    parameter int NUM_LINES = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr,
    input  logic                   wr_en,
    input  logic [1:0]             wr_be,
    input  logic [15:0]            wr_data,
    input  logic [$clog2(NUM_LINES)-1:0] sel_line,
    input  grp_e                   sel_grp,
    input  logic [NUM_LINES*8-1:0] tsc_i,
    input  logic [NUM_LINES*8-1:0] rms_i,
    output logic [15:0]            rd_data,
    output logic [NUM_LINES-1:0]   txb_push_o,
    output logic [7:0]             txb_data_o,
    output logic [NUM_LINES*8-1:0] lctl_o,
    output logic [NUM_LINES*8-1:0] tms_o,
    output logic [NUM_LINES*16-1:0] taddr_o,
    output logic [NUM_LINES*16-1:0] tcnt_o
);
    localparam int LW = $clog2(NUM_LINES);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic [7:0]  lctl_q, tms_q;
        logic [15:0] ta_q, tc_q;
        logic        hit;

        assign hit = wr_en && (sel_line == LW'(i));

        // Byte-lane update of the selected line's register in the chosen group.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                lctl_q <= '0;
                tms_q  <= '0;
                ta_q   <= '0;
                tc_q   <= '0;
            end else if (hit) begin
                case (sel_grp)
                    GRP_LCTL: begin
                        if (wr_be[0]) lctl_q <= wr_data[7:0] & LCTL_MASK;
                        if (wr_be[1]) tms_q  <= wr_data[15:8] & TMS_MASK;
                    end
                    GRP_TADDR: begin
                        if (wr_be[0]) ta_q[7:0]  <= wr_data[7:0];
                        if (wr_be[1]) ta_q[15:8] <= wr_data[15:8];
                    end
                    GRP_TCNT: begin
                        if (wr_be[0]) tc_q[7:0]  <= wr_data[7:0];
                        if (wr_be[1]) tc_q[15:8] <= wr_data[15:8];
                    end
                    default: ;
                endcase
            end
        end

        assign txb_push_o[i]       = hit && wr_be[0] && (sel_grp == GRP_TXBUF);
        assign lctl_o[i*8 +: 8]    = lctl_q;
        assign tms_o[i*8 +: 8]     = tms_q;
        assign taddr_o[i*16 +: 16] = ta_q;
        assign tcnt_o[i*16 +: 16]  = tc_q;

        // R5: a write without the high lane leaves every high byte of this line intact.
        assert_hi_byte_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (hit && !clr && !wr_be[1]) |=> ($stable(ta_q[15:8]) && $stable(tc_q[15:8]) && $stable(tms_q)));

        // R12: the master reset cycle leaves this line's registers at zero.
        assert_line_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
            clr |=> (lctl_q == '0 && tms_q == '0 && ta_q == '0 && tc_q == '0));
    end

    assign txb_data_o = wr_data[7:0];

    // Readback of the register picked by the pointer.
    always_comb begin
        unique case (sel_grp)
            GRP_TXBUF: rd_data = {rms_i[sel_line*8 +: 8] & RMS_MASK, tsc_i[sel_line*8 +: 8]};
            GRP_LCTL:  rd_data = {tms_o[sel_line*8 +: 8], lctl_o[sel_line*8 +: 8]};
            GRP_TADDR: rd_data = taddr_o[sel_line*16 +: 16];
            default:   rd_data = tcnt_o[sel_line*16 +: 16];
        endcase
    end

    // R6: at most one line receives a push strobe in any cycle.
    assert_push_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(txb_push_o));
endmodule

// File: rtl/mxr_csr.sv
// Module: control/status word. Holds pointer, enables, receive flag and the
// self-clearing master reset; pops the event queue on a status read.
// Assumes the event head is presented combinationally by the queue.
module mxr_csr
    import mxr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        csr_wr,
    input  logic        csr_rd,
    input  logic [1:0]  be,
    input  logic [15:0] wdata,
    input  logic        rx_evt,
    input  logic        head_valid,
    input  tx_evt_t     head,
    output logic [15:0] rdata,
    output logic [4:0]  iad_o,
    output logic        mreset_o,
    output logic        pop_o,
    output logic        tie_o,
    output logic        rie_o,
    output logic        ri_o
);
    logic [4:0] iad_q;
    logic       tie_q, rie_q, ri_q, clr_q;
    logic       unused_wdata;

    assign unused_wdata = ^{wdata[15], wdata[13:7]};

    // Writable fields; master reset clears them and itself one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_q) begin
            iad_q <= '0;
            tie_q <= 1'b0;
            rie_q <= 1'b0;
            clr_q <= 1'b0;
        end else if (csr_wr) begin
            if (be[0]) begin
                iad_q <= wdata[4:0];
                rie_q <= wdata[CSR_RIE];
                clr_q <= wdata[CSR_CLR];
            end
            if (be[1]) tie_q <= wdata[CSR_TIE];
        end
    end

    // Receive flag: set by an event (which wins), cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_q)  ri_q <= 1'b0;
        else if (rx_evt)      ri_q <= 1'b1;
        else if (csr_rd)      ri_q <= 1'b0;
    end

    assign pop_o = csr_rd && head_valid && !clr_q;

    // Status word assembly.
    always_comb begin
        rdata          = '0;
        rdata[CSR_TI]  = head_valid;
        rdata[CSR_TIE] = tie_q;
        rdata[CSR_NXM] = head_valid && head.nxm;
        rdata[10:8]    = head_valid ? head.line : '0;
        rdata[CSR_RI]  = ri_q;
        rdata[CSR_RIE] = rie_q;
        rdata[CSR_CLR] = clr_q;
        rdata[4:0]     = iad_q;
    end

    assign iad_o    = iad_q;
    assign mreset_o = clr_q;
    assign tie_o    = tie_q;
    assign rie_o    = rie_q;
    assign ri_o     = ri_q;

    // R12: the reset bit never stays set for two cycles.
    assert_clr_selfclear_R12: assert property (@(posedge clk) disable iff (!rst_n)
        clr_q |=> !clr_q);

    // R10: a receive event outside a reset cycle is visible in the next cycle.
    assert_ri_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_evt && !clr_q) |=> ri_q);
endmodule

// File: rtl/mux_regfront.sv
// Module: top of the multi-line register front end. Decodes the host word
// select, routes CSR and indirect accesses and forms the interrupt requests.
// Assumes single-cycle host strobes and pulse-style event inputs.
module mux_regfront
    import mxr_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int EVQ_DEPTH = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_sel,
    input  logic                    host_wr,
    input  logic                    host_rd,
    input  logic [1:0]              host_be,
    input  logic [15:0]             host_wdata,
    output logic [15:0]             host_rdata,
    input  logic                    tx_evt_i,
    input  logic [$clog2(NUM_LINES)-1:0] tx_evt_line_i,
    input  logic                    tx_evt_nxm_i,
    input  logic                    rx_evt_i,
    output logic                    tx_irq_o,
    output logic                    rx_irq_o,
    output logic                    mreset_o,
    output logic [NUM_LINES-1:0]    txb_push_o,
    output logic [7:0]              txb_data_o,
    input  logic [NUM_LINES*8-1:0]  tsc_i,
    input  logic [NUM_LINES*8-1:0]  rms_i,
    output logic [NUM_LINES*8-1:0]  lctl_o,
    output logic [NUM_LINES*8-1:0]  tms_o,
    output logic [NUM_LINES*16-1:0] taddr_o,
    output logic [NUM_LINES*16-1:0] tcnt_o
);
    localparam int LW = $clog2(NUM_LINES);

    logic [4:0]  iad;
    logic        mreset, evq_pop, head_valid, tie, rie, ri;
    logic [15:0] csr_rdata, ind_rdata;
    tx_evt_t     head_evt, evt_in;
    logic        unused_iad;

    assign unused_iad = ^iad;
    assign evt_in     = '{line: LINE_BITS'(tx_evt_line_i), nxm: tx_evt_nxm_i};

    mxr_csr u_csr (
        .clk        (clk),
        .rst_n      (rst_n),
        .csr_wr     (host_wr && !host_sel),
        .csr_rd     (host_rd && !host_sel),
        .be         (host_be),
        .wdata      (host_wdata),
        .rx_evt     (rx_evt_i),
        .head_valid (head_valid),
        .head       (head_evt),
        .rdata      (csr_rdata),
        .iad_o      (iad),
        .mreset_o   (mreset),
        .pop_o      (evq_pop),
        .tie_o      (tie),
        .rie_o      (rie),
        .ri_o       (ri)
    );

    mxr_evq #(.DEPTH(EVQ_DEPTH)) u_evq (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (mreset),
        .push       (tx_evt_i),
        .push_data  (evt_in),
        .pop        (evq_pop),
        .head_valid (head_valid),
        .head       (head_evt)
    );

    mxr_line_bank #(.NUM_LINES(NUM_LINES)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (mreset),
        .wr_en      (host_wr && host_sel && !mreset),
        .wr_be      (host_be),
        .wr_data    (host_wdata),
        .sel_line   (iad[LW-1:0]),
        .sel_grp    (grp_e'(iad[4:3])),
        .tsc_i      (tsc_i),
        .rms_i      (rms_i),
        .rd_data    (ind_rdata),
        .txb_push_o (txb_push_o),
        .txb_data_o (txb_data_o),
        .lctl_o     (lctl_o),
        .tms_o      (tms_o),
        .taddr_o    (taddr_o),
        .tcnt_o     (tcnt_o)
    );

    assign host_rdata = host_sel ? ind_rdata : csr_rdata;
    assign tx_irq_o   = head_valid && tie;
    assign rx_irq_o   = ri && rie;
    assign mreset_o   = mreset;

    // R11: a transmit request always coincides with a pending event shown in the status word.
    assert_txirq_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq_o |-> (csr_rdata[CSR_TI] && csr_rdata[CSR_TIE]));
endmodule

// File: tb/mux_regfront_tb_top.sv
// Bench: scoreboard. Read tasks queue the expected word; a monitor at the
// falling edge pops and compares it with the read data.
module mux_regfront_tb_top;
    localparam int NL = 8;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0, host_wr = 1'b0, host_rd = 1'b0;
    logic [1:0]  host_be = 2'b00;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        tx_evt = 1'b0, tx_nxm = 1'b0, rx_evt = 1'b0;
    logic [2:0]  tx_line = '0;
    logic        tx_irq, rx_irq, mreset;
    logic [NL-1:0]    txb_push;
    logic [7:0]       txb_data;
    logic [NL*8-1:0]  tsc, rms, lctl, tms;
    logic [NL*16-1:0] taddr, tcnt;

    always #2 clk = ~clk;

    mux_regfront #(.NUM_LINES(NL), .EVQ_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_be(host_be), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .tx_evt_i(tx_evt), .tx_evt_line_i(tx_line),
        .tx_evt_nxm_i(tx_nxm), .rx_evt_i(rx_evt), .tx_irq_o(tx_irq),
        .rx_irq_o(rx_irq), .mreset_o(mreset), .txb_push_o(txb_push),
        .txb_data_o(txb_data), .tsc_i(tsc), .rms_i(rms), .lctl_o(lctl),
        .tms_o(tms), .taddr_o(taddr), .tcnt_o(tcnt)
    );

    int checks = 0;
    int errors = 0;
    typedef struct { logic [15:0] v; string tag; } exp_t;
    exp_t exp_q[$];

    function automatic logic [7:0] tsc_val(int l); return 8'h10 + 8'(l); endfunction
    function automatic logic [7:0] rms_val(int l); return 8'(l * 32 + 7); endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compare every read against the oldest queued expectation.
    always @(negedge clk) begin : monitor
        exp_t e;
        if (host_rd) begin
            if (exp_q.size() == 0) check("scoreboard underrun", 64'd1, 64'd0);
            else begin
                e = exp_q.pop_front();
                check(e.tag, 64'(host_rdata), 64'(e.v));
            end
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic sel, input logic [1:0] be, input logic [15:0] d);
        host_sel = sel; host_be = be; host_wdata = d; host_wr = 1'b1;
        @(posedge clk); #1;
        host_wr = 1'b0; host_be = 2'b00;
    endtask

    task automatic rd(input logic sel, input logic [15:0] exp, input string tag);
        exp_q.push_back('{exp, tag});
        host_sel = sel; host_rd = 1'b1;
        @(posedge clk); #1;
        host_rd = 1'b0;
    endtask

    task automatic txev(input logic [2:0] l, input logic n);
        tx_evt = 1'b1; tx_line = l; tx_nxm = n;
        @(posedge clk); #1;
        tx_evt = 1'b0; tx_nxm = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stimulus
        for (int l = 0; l < NL; l++) begin
            tsc[l*8 +: 8] = tsc_val(l);
            rms[l*8 +: 8] = rms_val(l);
        end
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1: reset state
        rd(1'b0, 16'h0000, "R1 csr after reset");
        rd(1'b1, {rms_val(0) & 8'hFC, tsc_val(0)}, "R1 line0 txbuf readback");
        check("R1 lctl zero", lctl, '0);
        check("R1 irq low", {tx_irq, rx_irq}, 0);

        // R2: writable fields kept, read-only fields ignored
        wr(1'b0, 2'b11, 16'hDFDF);
        rd(1'b0, 16'h405F, "R2 csr writable and read-only bits");

        // R3: line control and modem status of line 3
        wr(1'b0, 2'b01, 16'h004B);
        wr(1'b1, 2'b11, 16'hFFFF);
        rd(1'b1, 16'hBF3F, "R3 line3 control readback masked");
        check("R3 lctl port line3", lctl[3*8 +: 8], 8'h3F);
        check("R3 tms port line3", tms[3*8 +: 8], 8'hBF);
        check("R3 other lines untouched", {lctl[2*8 +: 8], lctl[4*8 +: 8]}, 0);

        // R5 / R4: address and count of line 5
        wr(1'b0, 2'b01, 16'h0055);
        wr(1'b1, 2'b11, 16'h1234);
        wr(1'b1, 2'b10, 16'hAB00);
        rd(1'b1, 16'hAB34, "R5 high-lane write only");
        wr(1'b1, 2'b01, 16'hFFCD);
        rd(1'b1, 16'hABCD, "R5 low-lane write only");
        wr(1'b0, 2'b01, 16'h005D);
        wr(1'b1, 2'b11, 16'h5A5A);
        rd(1'b1, 16'h5A5A, "R4 count line5");
        check("R4 address kept line5", taddr[5*16 +: 16], 16'hABCD);
        check("R4 count port line5", tcnt[5*16 +: 16], 16'h5A5A);
        check("R4 other line count zero", tcnt[4*16 +: 16], 16'h0);

        // R6: push strobe on line 2
        wr(1'b0, 2'b01, 16'h0042);
        host_sel = 1'b1; host_be = 2'b01; host_wdata = 16'h77C3; host_wr = 1'b1;
        @(negedge clk);
        check("R6 push strobe line2", 64'(txb_push), 64'(8'h04));
        check("R6 push data", 64'(txb_data), 64'(8'hC3));
        @(posedge clk); #1;
        host_be = 2'b10;
        @(negedge clk);
        check("R6 high-only write no push", 64'(txb_push), 64'd0);
        @(posedge clk); #1;
        host_wr = 1'b0; host_be = 2'b00;
        rd(1'b1, {rms_val(2) & 8'hFC, tsc_val(2)}, "R6 txbuf readback line2");

        // R7 / R11: events in order
        txev(3'd6, 1'b0);
        txev(3'd1, 1'b1);
        check("R11 tx irq with pending event", 64'(tx_irq), 64'd1);
        rd(1'b0, 16'hC642, "R7 first event line6");
        rd(1'b0, 16'hE142, "R7 second event line1 with error");
        rd(1'b0, 16'h4042, "R7 queue empty");
        check("R11 tx irq idle", 64'(tx_irq), 64'd0);

        // R8: arrival in the pop cycle
        txev(3'd4, 1'b0);
        tx_evt = 1'b1; tx_line = 3'd7;
        rd(1'b0, 16'hC442, "R8 pop shows line4");
        tx_evt = 1'b0;
        rd(1'b0, 16'hC742, "R8 colliding event kept");
        rd(1'b0, 16'h4042, "R8 drained");

        // R9: overflow drops
        for (int l = 0; l <= DEPTH; l++) txev(3'(l), 1'b0);
        for (int l = 0; l < DEPTH; l++) rd(1'b0, 16'hC042 | 16'(l << 8), "R9 kept event");
        rd(1'b0, 16'h4042, "R9 extra event dropped");

        // R10 / R11: receive flag
        rx_evt = 1'b1; step(1); rx_evt = 1'b0;
        check("R11 rx irq", 64'(rx_irq), 64'd1);
        rd(1'b0, 16'h40C2, "R10 flag set");
        rd(1'b0, 16'h4042, "R10 flag cleared by read");
        rx_evt = 1'b1;
        rd(1'b0, 16'h4042, "R10 collision read value");
        rx_evt = 1'b0;
        rd(1'b0, 16'h40C2, "R10 set wins over clear");
        rd(1'b0, 16'h4042, "R10 cleared again");

        // R11: disabled enables gate the requests
        wr(1'b0, 2'b01, 16'h0002);
        wr(1'b0, 2'b10, 16'h0000);
        rx_evt = 1'b1; step(1); rx_evt = 1'b0;
        txev(3'd3, 1'b0);
        check("R11 irqs masked", {tx_irq, rx_irq}, 0);
        rd(1'b0, 16'h8382, "R11 flags still visible");

        // R12: master reset with an event pending
        txev(3'd5, 1'b0);
        wr(1'b0, 2'b11, 16'h4020);
        check("R12 mreset pulse", 64'(mreset), 64'd1);
        host_wdata = 16'hFFFF; host_be = 2'b11; host_sel = 1'b1; host_wr = 1'b1;
        host_wr = 1'b0;
        rd(1'b0, 16'hC520, "R12 reset cycle view");
        check("R12 mreset gone", 64'(mreset), 64'd0);
        rd(1'b0, 16'h0000, "R12 csr cleared");
        check("R12 lctl cleared", lctl, '0);
        check("R12 tms cleared", tms, '0);
        check("R12 address cleared", 64'(|taddr), 64'd0);
        check("R12 count cleared", 64'(|tcnt), 64'd0);
        wr(1'b0, 2'b01, 16'h000B);
        rd(1'b1, 16'h0000, "R12 line3 control cleared");

        step(2);
        check("scoreboard drained", 64'(exp_q.size()), 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule